// File: doc/BRIEF.md
# Text Display Mode Latches and Text Memory Gate

This block sits between a byte-wide CPU bus and the text side of a display subsystem. It holds eight single-bit display mode flags that software sets or clears one at a time through a write-only command port. A command byte carries the number of the flag to change in bits [3:1] and the new value in bit 0. Two flags get special handling. A command aimed at flag 1 never changes a flag. It arms an internal latch instead. Flag 4, which selects line-count mode, takes a new value only while that latch is armed, and the same command then disarms the latch.

The block also owns a 16 KB text memory and gates every CPU access to it. A write near the top of the memory, at offset 0x3FE2 or above, is stored only while flag 6 (the write-enable flag for that region) is 1. A read whose offset has both bit 13 and bit 0 set returns 0xFF without reading the memory. Every other read returns the stored byte one cycle later, with a valid strobe in the same cycle as the data.

The arming control is a two-state machine. Its states are ST_IDLE and ST_ARMED. The transition ARM (a command to flag 1) moves ST_IDLE to ST_ARMED, or keeps the machine in ST_ARMED. The transition COMMIT (a command to flag 4 in ST_ARMED) loads flag 4 and returns to ST_IDLE. In ST_IDLE a command to flag 4 is dropped. Commands to any other flag load that flag and leave the state unchanged. Reset forces ST_IDLE.

Top module: `txtvram_front`

## Requirements
- R1: A command byte with index field bits [3:1] equal to 0, 2, 3, 5, 6 or 7 loads bit 0 into that flag in the cycle after the write. Bits [7:4] have no effect.
- R2: A command with index 1 leaves all eight flags unchanged and arms the latch.
- R3: A command with index 4 while the latch is armed loads bit 0 into flag 4 and disarms the latch. A second index-4 command then has no effect.
- R4: A command with index 4 while the latch is not armed has no effect on any flag.
- R5: A text memory write below offset 0x3FE2 is always stored.
- R6: A text memory write at offset 0x3FE2 or above is stored only while flag 6 is 1. Otherwise the stored byte is left unchanged.
- R7: A read at an offset with bit 13 and bit 0 both set returns 0xFF, with valid asserted one cycle after the request.
- R8: Any other read returns the byte stored at that offset, with valid asserted and data presented one cycle after the request. Valid is low in cycles that follow no request.
- R9: Reset clears all eight flags and the arming latch.
- R10: Output bit n of mode_flags equals flag n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Command byte write strobe |
| mode_data | input | 8 | Command byte: [3:1] flag index, [0] value |
| cpu_rd | input | 1 | Text memory read request |
| cpu_wr | input | 1 | Text memory write request |
| cpu_addr | input | 14 | Text memory byte offset |
| cpu_wdata | input | 8 | Text memory write data |
| cpu_rdata | output | 8 | Read data, valid with cpu_rvalid |
| cpu_rvalid | output | 1 | Read data valid, one cycle after cpu_rd |
| mode_flags | output | 8 | The eight mode flags, bit n = flag n |

## Verification
The hardest case is an armed latch that reset must clear. Its only visible effect is a later flag-4 command that gets dropped. The stimulus arms the latch, applies reset and then sends an index-4 command with value 1. Flag 4 must stay 0. The protected region is handled in a similar indirect way. A known byte is first stored at 0x3FE2 while flag 6 is 1. Flag 6 is then cleared and a second byte is written to the same offset. Reading the offset back must return the first byte. Index-4 commands sent before arming, just after arming and a second time after a commit cover every transition of the arming state machine.

// File: rtl/txv_pkg.sv
package txv_pkg;
    localparam int FLAG_CNT  = 8;
    localparam int IDX_W     = $clog2(FLAG_CNT);
    localparam int ARM_IDX   = 1;
    localparam int GATE_IDX  = 4;
    localparam int PROT_IDX  = 6;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } arm_state_t;
endpackage

// File: rtl/txv_mode_bank.sv
module txv_mode_bank
    import txv_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [DATA_W-1:0]   data,
    output logic [FLAG_CNT-1:0] flags
);
    localparam logic [IDX_W-1:0] ARM_SEL  = IDX_W'(ARM_IDX);
    localparam logic [IDX_W-1:0] GATE_SEL = IDX_W'(GATE_IDX);

    arm_state_t          state_q, state_d;
    logic [FLAG_CNT-1:0] load;
    logic [FLAG_CNT-1:0] flags_q;
    logic [IDX_W-1:0]    sel;
    logic                val;

    assign sel = data[IDX_W:1];
    assign val = data[0];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and load strobes
    always_comb begin
        state_d = state_q;
        load    = '0;
        if (wr) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (sel == ARM_SEL)       state_d = ST_ARMED;
                    else if (sel != GATE_SEL) load[sel] = 1'b1;
                end
                ST_ARMED: begin
                    if (sel == GATE_SEL) begin
                        load[sel] = 1'b1;
                        state_d   = ST_IDLE;
                    end else if (sel != ARM_SEL) begin
                        load[sel] = 1'b1;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    for (genvar g = 0; g < FLAG_CNT; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)       flags_q[g] <= 1'b0;
            else if (load[g]) flags_q[g] <= val;
        end
    end

    assign flags = flags_q;

    // R2
    arm_on_graphic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == ARM_SEL) |=> (state_q == ST_ARMED));

    // R2
    graphic_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == ARM_SEL) |=> $stable(flags_q));

    // R3
    lines_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[GATE_IDX] != $past(flags_q[GATE_IDX])) |-> ($past(state_q) == ST_ARMED));

    // R3
    commit_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == GATE_SEL && state_q == ST_ARMED) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/txv_ram.sv
module txv_ram #(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        if (re) rd_q <= mem[addr];
    end

    assign rdata = rd_q;
endmodule

// File: rtl/txv_rd_path.sv
module txv_rd_path #(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 8,
    parameter int MASK_HI = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] ram_q,
    output logic              ram_re,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    logic masked;
    logic masked_q;
    logic valid_q;

    assign masked = addr[MASK_HI] & addr[0];
    assign ram_re = rd & ~masked;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            masked_q <= 1'b0;
        end else begin
            valid_q  <= rd;
            masked_q <= rd & masked;
        end
    end

    assign rvalid = valid_q;
    assign rdata  = masked_q ? {DATA_W{1'b1}} : ram_q;

    // R8
    rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rvalid);

    // R8
    rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> !rvalid);

    // R7
    mask_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr[MASK_HI] && addr[0]) |=> (rdata == {DATA_W{1'b1}}));
endmodule

// File: rtl/txtvram_front.sv
module txtvram_front
    import txv_pkg::*;
#(
    parameter int          ADDR_W    = 14,
    parameter int          DATA_W    = 8,
    parameter logic [13:0] PROT_BASE = 14'h3FE2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [DATA_W-1:0] mode_data,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_rvalid,
    output logic [FLAG_CNT-1:0] mode_flags
);
    localparam logic [ADDR_W-1:0] PROT_LIM = ADDR_W'(PROT_BASE);

    logic              ram_we;
    logic              ram_re;
    logic [DATA_W-1:0] ram_q;
    logic              in_prot;

    txv_mode_bank #(.DATA_W(DATA_W)) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (mode_wr),
        .data  (mode_data),
        .flags (mode_flags)
    );

    assign in_prot = (cpu_addr >= PROT_LIM);
    assign ram_we  = cpu_wr & (~in_prot | mode_flags[PROT_IDX]);

    txv_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .re    (ram_re),
        .addr  (cpu_addr),
        .wdata (cpu_wdata),
        .rdata (ram_q)
    );

    txv_rd_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK_HI(13)) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd     (cpu_rd),
        .addr   (cpu_addr),
        .ram_q  (ram_q),
        .ram_re (ram_re),
        .rdata  (cpu_rdata),
        .rvalid (cpu_rvalid)
    );

    // R6
    prot_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr >= PROT_LIM && !mode_flags[PROT_IDX]) |-> !ram_we);

    // R5
    low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr < PROT_LIM) |-> ram_we);

    // R9
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mode_flags == '0));
endmodule

// File: tb/sim_txtvram_front.sv
`timescale 1ns/1ps
module sim_txtvram_front;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_wr = 1'b0;
    logic [7:0] mode_data = 8'h00;
    logic       cpu_rd = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [13:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       cpu_rvalid;
    logic [7:0] mode_flags;

    int errors = 0;
    int checks = 0;
    logic [7:0] exp_flags = 8'h00;

    always #5 clk = ~clk;

    txtvram_front u0 (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_data(mode_data),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
        .mode_flags(mode_flags)
    );

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        exp_flags = 8'h00;
    endtask

    task automatic mode_cmd(input logic [7:0] d);
        @(negedge clk);
        mode_wr = 1'b1;
        mode_data = d;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic ram_wr(input logic [13:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1;
        cpu_addr = a;
        cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic ram_rd(input logic [13:0] a, output logic [7:0] d, output logic v);
        @(negedge clk);
        cpu_rd = 1'b1;
        cpu_addr = a;
        @(negedge clk);
        cpu_rd = 1'b0;
        d = cpu_rdata;
        v = cpu_rvalid;
    endtask

    task automatic t_reset();
        check8("R9 flags after reset", mode_flags, 8'h00);
        check8("R8 rvalid idle", {7'b0, cpu_rvalid}, 8'h00);
    endtask

    task automatic t_direct();
        mode_cmd(8'h01); exp_flags[0] = 1'b1;
        check8("R1 flag0 set", mode_flags, exp_flags);
        mode_cmd(8'hF5); exp_flags[2] = 1'b1;
        check8("R1 upper bits ignored flag2", mode_flags, exp_flags);
        mode_cmd(8'h0F); exp_flags[7] = 1'b1;
        check8("R10 flag7 on bit7", mode_flags, exp_flags);
        mode_cmd(8'h04); exp_flags[2] = 1'b0;
        check8("R1 flag2 clear", mode_flags, exp_flags);
    endtask

    task automatic t_arm_gate();
        mode_cmd(8'h09);
        check8("R4 unarmed idx4 ignored", mode_flags, exp_flags);
        mode_cmd(8'h03);
        check8("R2 idx1 no flag change", mode_flags, exp_flags);
        mode_cmd(8'h09); exp_flags[4] = 1'b1;
        check8("R3 armed idx4 commits", mode_flags, exp_flags);
        mode_cmd(8'h08);
        check8("R3 second idx4 ignored", mode_flags, exp_flags);
        mode_cmd(8'h02);
        mode_cmd(8'h0B);
        mode_cmd(8'h08); exp_flags[4] = 1'b0;
        check8("R3 armed idx4 clears, arm persists past idx5", mode_flags, {exp_flags[7:6], 1'b1, exp_flags[4:0]});
        exp_flags[5] = 1'b1;
    endtask

    task automatic t_reset_disarm();
        mode_cmd(8'h02);
        do_reset();
        mode_cmd(8'h09);
        check8("R9 reset clears arm latch", mode_flags, 8'h00);
    endtask

    task automatic t_memory();
        logic [7:0] d;
        logic v;
        ram_wr(14'h0010, 8'hA5);
        ram_rd(14'h0010, d, v);
        check8("R8 read data", d, 8'hA5);
        check8("R8 read valid", {7'b0, v}, 8'h01);
        ram_wr(14'h3FE1, 8'h33);
        ram_rd(14'h3FE1, d, v);
        check8("R7 masked read 3FE1", d, 8'hFF);
        ram_wr(14'h0001, 8'h5C);
        ram_rd(14'h0001, d, v);
        check8("R5 low odd read stored", d, 8'h5C);
        ram_wr(14'h2000, 8'h77);
        ram_rd(14'h2000, d, v);
        check8("R8 bit13 even read stored", d, 8'h77);
        ram_rd(14'h2001, d, v);
        check8("R7 masked read 2001", d, 8'hFF);
        check8("R7 masked valid", {7'b0, v}, 8'h01);
        ram_wr(14'h3FE0, 8'h44);
        ram_rd(14'h3FE0, d, v);
        check8("R5 just below limit", d, 8'h44);
        mode_cmd(8'h0D);
        ram_wr(14'h3FE2, 8'h11);
        ram_rd(14'h3FE2, d, v);
        check8("R6 protected write enabled", d, 8'h11);
        mode_cmd(8'h0C);
        ram_wr(14'h3FE2, 8'h22);
        ram_rd(14'h3FE2, d, v);
        check8("R6 protected write blocked", d, 8'h11);
        ram_wr(14'h3FE0, 8'h66);
        ram_rd(14'h3FE0, d, v);
        check8("R5 below limit with flag6 clear", d, 8'h66);
        @(negedge clk);
        check8("R8 rvalid low without request", {7'b0, cpu_rvalid}, 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_direct();
        t_arm_gate();
        t_reset_disarm();
        t_memory();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule